// File: doc/BRIEF.md
# Trap-Return Status Update Unit

This unit carries out the two trap-return instructions of a privileged processor core: the supervisor-level return and the machine-level return. The pipeline presents a return request for one cycle, together with the current privilege level, the virtualization flag, the machine status word, the hypervisor status word and both saved exception PCs. The unit first decides whether the return is legal. If it is, the unit computes the rewritten status words, the privilege level and virtualization state to resume in, and the return PC. If it is not, the unit reports an exception code.

All results are registered. One cycle after a request, exactly one of two pulses is high: `done` for a committed return or `exc_valid` for a refused one. On a refused return, the status, mode and PC outputs keep their previous values. The unit does not swap the hypervisor register banks. When a return enters a virtualized mode that needs the guest banks, it raises `bank_swap` alongside `done` so that neighbouring logic can do the swap.

Encodings used throughout:
- Privilege: U=0, S=1, M=3.
- Machine status bits: SIE at 1, MIE at 3, SPIE at 5, MPIE at 7, SPP at 8, MPP at 12:11, MPRV at 17, TSR (trap supervisor return) at 22, MPV at 39.
- Hypervisor status bits: SPV at 7, VTSR (virtual trap supervisor return) at 22.
- Exception codes: 0 = misaligned target, 2 = illegal instruction, 22 = virtual-instruction fault.

Top module: `trapret_unit`

## Requirements
- R1: Supervisor return raises code 2 when the current privilege is U. It also raises code 2 when TSR is set and the privilege is below M. TSR has no effect at privilege M.
- R2: A virtualized supervisor return with VTSR set raises code 22, unless a code-2 condition from R1 applies first.
- R3: When `rvc_ok` is 0 and the selected saved PC has a non-zero value in bits 1:0, the return raises code 0. This check ranks below the privilege-level check and above the TSR check. `ret_pc` is the selected saved PC with bit 0 cleared.
- R4: A committed supervisor return writes SIE from the old SPIE, sets SPIE to 1, clears SPP and clears MPRV. The new privilege is S if the old SPP was 1 and U otherwise.
- R5: A supervisor return from the non-virtualized state with `h_present`=1 takes the new virtualization state from SPV and clears SPV, and `bank_swap` pulses if SPV was 1. Otherwise the virtualization state is kept and the hypervisor status passes through unchanged.
- R6: Machine return raises code 2 unless the current privilege is M.
- R7: A committed machine return writes MIE from the old MPIE and sets MPIE to 1. It sets MPP to U when `u_present`=1 and to M otherwise, and clears MPV. The new privilege is the old MPP.
- R8: The new virtualization state after a machine return is MPV AND (old MPP is not M). `bank_swap` pulses when that is 1 and `h_present`=1.
- R9: Machine return clears MPRV only when the old MPP is not M. Otherwise MPRV keeps its value.
- R10: Exactly one of `done`/`exc_valid` pulses in the cycle after each request, and neither pulses without a request. A refused return leaves the status, mode and PC outputs unchanged. After reset all outputs are zero except `new_priv`, which is M.
- R11: Status bits that R4, R7 and R9 do not name are copied unchanged into `mstat_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Return request, one cycle |
| req_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current virtualization state |
| mstat_in | input | 64 | Machine status word |
| hstat_in | input | 64 | Hypervisor status word |
| sepc | input | XLEN | Saved supervisor exception PC |
| mepc | input | XLEN | Saved machine exception PC |
| rvc_ok | input | 1 | Compressed instructions supported |
| u_present | input | 1 | User mode implemented |
| h_present | input | 1 | Hypervisor support implemented |
| done | output | 1 | Return committed (pulse) |
| exc_valid | output | 1 | Return refused (pulse) |
| exc_code | output | 5 | Exception code of the last refused return |
| mstat_out | output | 64 | Updated machine status word |
| hstat_out | output | 64 | Updated hypervisor status word |
| new_priv | output | 2 | Privilege level to resume in |
| new_virt | output | 1 | Virtualization state to resume in |
| ret_pc | output | XLEN | Return target PC |
| bank_swap | output | 1 | Request to swap hypervisor register banks (pulse) |

## Verification
The hardest situations to reach are the ones where several refusal causes hold at once, so that only the priority order decides the code. Examples are a virtualized supervisor return with both TSR and VTSR set, and a return from U with a misaligned target. The stimulus table stacks these conditions on purpose. Each saved-PC input carries a distinct value, so a swapped PC selection shows up in `ret_pc`. Every refused return is checked against the outputs the previous commit left behind.

// File: rtl/trapret_pkg.sv
package trapret_pkg;
  localparam int STAT_W = 64;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // machine status bit positions (decoded by neighbouring logic)
  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_SPIE = 5;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_MPP0 = 11;
  localparam int B_MPP1 = 12;
  localparam int B_MPRV = 17;
  localparam int B_TSR  = 22;
  localparam int B_MPV  = 39;

  // hypervisor status bit positions
  localparam int B_SPV  = 7;
  localparam int B_VTSR = 22;

  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] EXC_MISALIGN = 5'd0;
  localparam logic [CODE_W-1:0] EXC_ILLEGAL  = 5'd2;
  localparam logic [CODE_W-1:0] EXC_VIRT     = 5'd22;

  typedef struct packed {
    logic                fault;
    logic [CODE_W-1:0]   code;
  } trap_t;
endpackage

// File: rtl/trapret_pc_select.sv
module trapret_pc_select #(
  parameter int XLEN = 32
) (
  input  logic            is_mret,
  input  logic [XLEN-1:0] sepc,
  input  logic [XLEN-1:0] mepc,
  output logic [1:0]      low_bits,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] chosen;

  always_comb begin
    chosen   = is_mret ? mepc : sepc;
    low_bits = chosen[1:0];
    target   = {chosen[XLEN-1:1], 1'b0};
  end
endmodule

// File: rtl/trapret_legality.sv
module trapret_legality
  import trapret_pkg::*;
(
  input  logic       is_mret,
  input  logic [1:0] cur_priv,
  input  logic       cur_virt,
  input  logic       tsr,
  input  logic       vtsr,
  input  logic       rvc_ok,
  input  logic [1:0] pc_low,
  output trap_t      verdict
);
  logic misaligned;

  always_comb begin
    misaligned = !rvc_ok && (pc_low != 2'b00);
    verdict    = '{fault: 1'b0, code: EXC_MISALIGN};
    if (is_mret) begin
      if (cur_priv != PRIV_M)
        verdict = '{fault: 1'b1, code: EXC_ILLEGAL};
      else if (misaligned)
        verdict = '{fault: 1'b1, code: EXC_MISALIGN};
    end else begin
      if (cur_priv < PRIV_S)
        verdict = '{fault: 1'b1, code: EXC_ILLEGAL};
      else if (misaligned)
        verdict = '{fault: 1'b1, code: EXC_MISALIGN};
      else if (tsr && (cur_priv < PRIV_M))
        verdict = '{fault: 1'b1, code: EXC_ILLEGAL};
      else if (cur_virt && vtsr)
        verdict = '{fault: 1'b1, code: EXC_VIRT};
    end
  end
endmodule

// File: rtl/trapret_status_calc.sv
module trapret_status_calc
  import trapret_pkg::*;
(
  input  logic              is_mret,
  input  logic              cur_virt,
  input  logic              u_present,
  input  logic              h_present,
  input  logic [STAT_W-1:0] mstat,
  input  logic [STAT_W-1:0] hstat,
  output logic [STAT_W-1:0] mstat_nxt,
  output logic [STAT_W-1:0] hstat_nxt,
  output logic [1:0]        prev_priv,
  output logic              prev_virt,
  output logic              swap
);
  logic [1:0] saved_mpp;
  logic       leaves_m;

  always_comb begin
    saved_mpp = {mstat[B_MPP1], mstat[B_MPP0]};
    leaves_m  = (saved_mpp != PRIV_M);
    mstat_nxt = mstat;
    hstat_nxt = hstat;
    prev_priv = PRIV_U;
    prev_virt = cur_virt;
    swap      = 1'b0;
    if (is_mret) begin
      prev_priv         = saved_mpp;
      prev_virt         = mstat[B_MPV] && leaves_m;
      mstat_nxt[B_MIE]  = mstat[B_MPIE];
      mstat_nxt[B_MPIE] = 1'b1;
      mstat_nxt[B_MPP1] = !u_present;
      mstat_nxt[B_MPP0] = !u_present;
      mstat_nxt[B_MPV]  = 1'b0;
      if (leaves_m)
        mstat_nxt[B_MPRV] = 1'b0;
      swap = h_present && prev_virt;
    end else begin
      prev_priv         = mstat[B_SPP] ? PRIV_S : PRIV_U;
      mstat_nxt[B_SIE]  = mstat[B_SPIE];
      mstat_nxt[B_SPIE] = 1'b1;
      mstat_nxt[B_SPP]  = 1'b0;
      mstat_nxt[B_MPRV] = 1'b0;
      if (h_present && !cur_virt) begin
        prev_virt        = hstat[B_SPV];
        hstat_nxt[B_SPV] = 1'b0;
        swap             = hstat[B_SPV];
      end
    end
  end
endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
  import trapret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_mret,
  input  logic [1:0]        cur_priv,
  input  logic              cur_virt,
  input  logic [63:0]       mstat_in,
  input  logic [63:0]       hstat_in,
  input  logic [XLEN-1:0]   sepc,
  input  logic [XLEN-1:0]   mepc,
  input  logic              rvc_ok,
  input  logic              u_present,
  input  logic              h_present,
  output logic              done,
  output logic              exc_valid,
  output logic [4:0]        exc_code,
  output logic [63:0]       mstat_out,
  output logic [63:0]       hstat_out,
  output logic [1:0]        new_priv,
  output logic              new_virt,
  output logic [XLEN-1:0]   ret_pc,
  output logic              bank_swap
);
  logic [1:0]        pc_low;
  logic [XLEN-1:0]   target;
  trap_t             verdict;
  logic [STAT_W-1:0] mstat_nxt, hstat_nxt;
  logic [1:0]        prev_priv;
  logic              prev_virt, swap;
  logic              commit;

  trapret_pc_select #(.XLEN(XLEN)) u_pc (
    .is_mret (req_is_mret),
    .sepc    (sepc),
    .mepc    (mepc),
    .low_bits(pc_low),
    .target  (target)
  );

  trapret_legality u_legal (
    .is_mret (req_is_mret),
    .cur_priv(cur_priv),
    .cur_virt(cur_virt),
    .tsr     (mstat_in[B_TSR]),
    .vtsr    (hstat_in[B_VTSR]),
    .rvc_ok  (rvc_ok),
    .pc_low  (pc_low),
    .verdict (verdict)
  );

  trapret_status_calc u_stat (
    .is_mret  (req_is_mret),
    .cur_virt (cur_virt),
    .u_present(u_present),
    .h_present(h_present),
    .mstat    (mstat_in),
    .hstat    (hstat_in),
    .mstat_nxt(mstat_nxt),
    .hstat_nxt(hstat_nxt),
    .prev_priv(prev_priv),
    .prev_virt(prev_virt),
    .swap     (swap)
  );

  assign commit = req_valid && !verdict.fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      exc_valid <= 1'b0;
      exc_code  <= '0;
      mstat_out <= '0;
      hstat_out <= '0;
      new_priv  <= PRIV_M;
      new_virt  <= 1'b0;
      ret_pc    <= '0;
      bank_swap <= 1'b0;
    end else begin
      done      <= commit;
      exc_valid <= req_valid && verdict.fault;
      bank_swap <= commit && swap;
      if (req_valid && verdict.fault)
        exc_code <= verdict.code;
      if (commit) begin
        mstat_out <= mstat_nxt;
        hstat_out <= hstat_nxt;
        new_priv  <= prev_priv;
        new_virt  <= prev_virt;
        ret_pc    <= target;
      end
    end
  end
endmodule

// File: rtl/trapret_chk.sv
module trapret_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_is_mret,
  input logic [1:0]      cur_priv,
  input logic            rvc_ok,
  input logic            done,
  input logic            exc_valid,
  input logic [63:0]     mstat_out,
  input logic [1:0]      new_priv,
  input logic            new_virt,
  input logic [XLEN-1:0] ret_pc,
  input logic            bank_swap
);
  assert_single_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && exc_valid));

  assert_outcome_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
    (done || exc_valid) |-> $past(req_valid));

  assert_hold_on_fault_R10: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> ($stable(mstat_out) && $stable(new_priv) && $stable(ret_pc)));

  assert_mret_from_m_R6: assert property (@(posedge clk) disable iff (rst)
    (done && $past(req_is_mret)) |-> ($past(cur_priv) == 2'd3));

  assert_sret_fields_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(req_is_mret)) |-> (mstat_out[5] && !mstat_out[8] && !mstat_out[17]));

  assert_mret_fields_R7: assert property (@(posedge clk) disable iff (rst)
    (done && $past(req_is_mret)) |-> (mstat_out[7] && !mstat_out[39]));

  assert_mprv_below_m_R9: assert property (@(posedge clk) disable iff (rst)
    (done && new_priv != 2'd3) |-> !mstat_out[17]);

  assert_aligned_target_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(rvc_ok)) |-> (ret_pc[1:0] == 2'b00));

  assert_swap_with_virt_R8: assert property (@(posedge clk) disable iff (rst)
    bank_swap |-> (done && new_virt));
endmodule

bind trapret_unit trapret_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_is_mret(req_is_mret),
  .cur_priv   (cur_priv),
  .rvc_ok     (rvc_ok),
  .done       (done),
  .exc_valid  (exc_valid),
  .mstat_out  (mstat_out),
  .new_priv   (new_priv),
  .new_virt   (new_virt),
  .ret_pc     (ret_pc),
  .bank_swap  (bank_swap)
);

// File: tb/sim_trapret_unit.sv
`timescale 1ns/1ps
module sim_trapret_unit;
  localparam int XL = 32;

  typedef struct packed {
    logic        op;
    logic [1:0]  priv;
    logic        virt;
    logic        rvc;
    logic        up;
    logic        hp;
    logic [63:0] ms;
    logic [63:0] hs;
    logic [31:0] epc;
    logic        ex;
    logic [4:0]  code;
    logic [1:0]  npriv;
    logic        nvirt;
    logic        swap;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 64'h20880, 64'h0, 32'h1000, 1'b0, 5'd0, 2'd1, 1'b0, 1'b0},              // R7 R9
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 64'h8000_0000_0002_1808, 64'h0, 32'h1004, 1'b0, 5'd0, 2'd3, 1'b0, 1'b0}, // R7 R9 R11
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0, 64'h0, 32'h1008, 1'b1, 5'd2, 2'd0, 1'b0, 1'b0},                   // R6
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1800, 64'h0, 32'h100c, 1'b0, 5'd0, 2'd3, 1'b0, 1'b0},                // R7
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 64'h80_0000_0000, 64'h0, 32'h1010, 1'b0, 5'd0, 2'd0, 1'b1, 1'b1},        // R8
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 64'h80_0000_1800, 64'h0, 32'h1014, 1'b0, 5'd0, 2'd3, 1'b0, 1'b0},        // R8
    '{1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 32'h1002, 1'b1, 5'd0, 2'd0, 1'b0, 1'b0},                   // R3
    '{1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 32'h1002, 1'b1, 5'd2, 2'd0, 1'b0, 1'b0},                   // R6 R3
    '{1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h20120, 64'h80, 32'h2000, 1'b0, 5'd0, 2'd1, 1'b1, 1'b1},              // R4 R5
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0, 64'h0, 32'h2004, 1'b1, 5'd2, 2'd0, 1'b0, 1'b0},                   // R1
    '{1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h400000, 64'h0, 32'h2008, 1'b1, 5'd2, 2'd0, 1'b0, 1'b0},              // R1
    '{1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 64'h400000, 64'h0, 32'h200c, 1'b0, 5'd0, 2'd0, 1'b0, 1'b0},              // R1 R4
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0, 64'h400000, 32'h2010, 1'b1, 5'd22, 2'd0, 1'b0, 1'b0},             // R2
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 64'h400000, 64'h400000, 32'h2014, 1'b1, 5'd2, 2'd0, 1'b0, 1'b0},         // R2
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 64'h100, 64'h80, 32'h2018, 1'b0, 5'd0, 2'd1, 1'b1, 1'b0},                // R5
    '{1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 32'h2001, 1'b1, 5'd0, 2'd0, 1'b0, 1'b0},                   // R3
    '{1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0, 64'h0, 32'h2003, 1'b0, 5'd0, 2'd0, 1'b0, 1'b0},                   // R3
    '{1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0, 64'h80, 32'h201c, 1'b0, 5'd0, 2'd0, 1'b0, 1'b0}                   // R5
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_is_mret = 1'b0;
  logic [1:0] cur_priv = 2'd0;
  logic cur_virt = 1'b0;
  logic [63:0] mstat_in = '0, hstat_in = '0;
  logic [XL-1:0] sepc = '0, mepc = '0;
  logic rvc_ok = 1'b1, u_present = 1'b1, h_present = 1'b1;
  logic done, exc_valid, new_virt, bank_swap;
  logic [4:0] exc_code;
  logic [63:0] mstat_out, hstat_out;
  logic [1:0] new_priv;
  logic [XL-1:0] ret_pc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  trapret_unit #(.XLEN(XL)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_mret(req_is_mret),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .mstat_in(mstat_in), .hstat_in(hstat_in),
    .sepc(sepc), .mepc(mepc), .rvc_ok(rvc_ok), .u_present(u_present), .h_present(h_present),
    .done(done), .exc_valid(exc_valid), .exc_code(exc_code), .mstat_out(mstat_out),
    .hstat_out(hstat_out), .new_priv(new_priv), .new_virt(new_virt), .ret_pc(ret_pc),
    .bank_swap(bank_swap)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected machine status from R4, R7, R9, R11
  function automatic logic [63:0] mdl_m(input vec_t v);
    logic [63:0] m = v.ms;
    if (v.op) begin
      m[3] = v.ms[7];
      m[7] = 1'b1;
      m[12:11] = v.up ? 2'd0 : 2'd3;
      m[39] = 1'b0;
      if (v.ms[12:11] != 2'd3) m[17] = 1'b0;
    end else begin
      m[1] = v.ms[5];
      m[5] = 1'b1;
      m[8] = 1'b0;
      m[17] = 1'b0;
    end
    return m;
  endfunction

  // expected hypervisor status from R5
  function automatic logic [63:0] mdl_h(input vec_t v);
    logic [63:0] h = v.hs;
    if (!v.op && v.hp && !v.virt) h[7] = 1'b0;
    return h;
  endfunction

  function automatic string vtag(input vec_t v);
    if (v.op) return v.ex ? "R6/R3 mret-refuse" : "R7/R8/R9 mret";
    return v.ex ? "R1/R2/R3 sret-refuse" : "R4/R5 sret";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] last_m, last_h;
    logic [1:0] last_priv;
    logic last_virt;
    logic [XL-1:0] last_pc;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10", "reset done", {63'd0, done}, 64'd0);
    chk("R10", "reset exc_valid", {63'd0, exc_valid}, 64'd0);
    chk("R10", "reset new_priv", {62'd0, new_priv}, 64'd3);
    chk("R10", "reset mstat_out", mstat_out, 64'd0);
    chk("R10", "reset ret_pc", {32'd0, ret_pc}, 64'd0);
    last_m = '0; last_h = '0; last_priv = 2'd3; last_virt = 1'b0; last_pc = '0;

    // R10: no request, no outcome, even with a refusable setup presented
    req_is_mret = 1'b1; cur_priv = 2'd0; mstat_in = 64'hFFFF;
    @(negedge clk);
    chk("R10", "idle done", {63'd0, done}, 64'd0);
    chk("R10", "idle exc_valid", {63'd0, exc_valid}, 64'd0);
    chk("R10", "idle mstat_out", mstat_out, last_m);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      req_valid = 1'b1; req_is_mret = v.op; cur_priv = v.priv; cur_virt = v.virt;
      rvc_ok = v.rvc; u_present = v.up; h_present = v.hp;
      mstat_in = v.ms; hstat_in = v.hs;
      sepc = v.op ? 32'hBEEF0000 : v.epc;
      mepc = v.op ? v.epc : 32'hDEAD0000;
      @(negedge clk);
      req_valid = 1'b0;
      chk(vtag(v), $sformatf("vec %0d done", i), {63'd0, done}, {63'd0, !v.ex});
      chk(vtag(v), $sformatf("vec %0d exc_valid", i), {63'd0, exc_valid}, {63'd0, v.ex});
      if (v.ex) begin
        chk(vtag(v), $sformatf("vec %0d code", i), {59'd0, exc_code}, {59'd0, v.code});
        chk("R10", $sformatf("vec %0d mstat held", i), mstat_out, last_m);
        chk("R10", $sformatf("vec %0d priv held", i), {62'd0, new_priv}, {62'd0, last_priv});
        chk("R10", $sformatf("vec %0d pc held", i), {32'd0, ret_pc}, {32'd0, last_pc});
        chk("R10", $sformatf("vec %0d hstat held", i), hstat_out, last_h);
        chk("R10", $sformatf("vec %0d virt held", i), {63'd0, new_virt}, {63'd0, last_virt});
      end else begin
        chk(vtag(v), $sformatf("vec %0d mstat", i), mstat_out, mdl_m(v));
        chk(vtag(v), $sformatf("vec %0d hstat", i), hstat_out, mdl_h(v));
        chk(vtag(v), $sformatf("vec %0d priv", i), {62'd0, new_priv}, {62'd0, v.npriv});
        chk(vtag(v), $sformatf("vec %0d virt", i), {63'd0, new_virt}, {63'd0, v.nvirt});
        chk(vtag(v), $sformatf("vec %0d swap", i), {63'd0, bank_swap}, {63'd0, v.swap});
        chk("R3", $sformatf("vec %0d ret_pc", i), {32'd0, ret_pc}, {32'd0, v.epc & 32'hFFFF_FFFE});
        last_m = mdl_m(v); last_h = mdl_h(v); last_priv = v.npriv;
        last_virt = v.nvirt; last_pc = v.epc & 32'hFFFF_FFFE;
      end
      @(negedge clk);
      // R10: outcomes are single-cycle pulses
      chk("R10", $sformatf("vec %0d pulse end", i), {61'd0, done, exc_valid, bank_swap}, 64'd0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule